// File: doc/BRIEF.md
# Masked Sum-of-Products Trigger Matcher

This block inspects each captured record of packet headers and decides whether the record satisfies a trigger condition. The condition is a sum of products: up to `NTERM` terms are ORed together. Each term names one packet type code and holds a value vector plus a care vector over the header. A header bit whose care bit is 0 is a don't-care. A term matches a packet when the type codes are equal and every cared bit of the header equals the term's value bit. A record hits when any active term matches any occupied slot of the record.

Each record comes out one cycle later with its header unchanged and a tag marking it as trigger data. A local trigger flag latches on the first qualified hit and stays set. A second latched flag captures the cross-trigger pulse from a partner module. The local flag is meant to drive the partner's cross-trigger input. Three option inputs change the behaviour. The first makes local hits wait until a cross trigger has been seen. The second suppresses all triggering. The third forwards only the records that qualify.

Top module: `trig_sop_matcher`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid`, `out_tag`, `trig_local` and `trig_cross` are all 0.
- R2: Term t matches slot s when `((hdr_s ^ val_t) & care_t) == 0` and the slot's type code equals the term's type code. Slot s occupies bits `[s*HDR_W +: HDR_W]` of `rec_hdr` and bits `[s*TYPE_W +: TYPE_W]` of `rec_ptype`. Term t occupies the same kind of position in the configuration vectors.
- R3: A term with type code 0 is unused and never matches, even when its care vector is all zeros.
- R4: Type gating is an exact compare of the codes. Distinct codes, such as a plain-address and an extended-address variant of one packet kind, never match the same term.
- R5: A record hits when any active term matches any slot whose `rec_pvld` bit is 1. A slot whose `rec_pvld` bit is 0 is ignored.
- R6: `trig_local` sets on a qualified hit. It stays set until `trig_clr` or `link_rst` is 1 at a clock edge, and a clear wins over a set in the same cycle.
- R7: `trig_cross` sets on a clock edge where `cross_in` is 1. It stays set until `trig_clr` or `link_rst`, and the clear wins.
- R8: With `opt_wait_cross` at 1, a hit qualifies only when `cross_in` is 1 or `trig_cross` is already set.
- R9: With `opt_disable` at 1, no hit qualifies: `out_tag` stays 0 and `trig_local` does not set.
- R10: With `opt_select` at 1, only qualifying records appear with `out_valid` at 1. With `opt_select` at 0, every input record is forwarded.
- R11: A record presented with `rec_valid` at 1 appears on `out_valid`, `out_tag` and `out_hdr` exactly one clock later. The header is unchanged, and `out_tag` is 1 exactly when the record qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Input record present |
| rec_hdr | input | PKTS*HDR_W | Packet headers, one slot per packet |
| rec_ptype | input | PKTS*TYPE_W | Packet type code per slot |
| rec_pvld | input | PKTS | Slot occupied flags |
| cfg_type | input | NTERM*TYPE_W | Type code per term, 0 = unused |
| cfg_val | input | NTERM*HDR_W | Value vector per term |
| cfg_care | input | NTERM*HDR_W | Care vector per term, 1 = compare |
| opt_wait_cross | input | 1 | Hold local hits until a cross trigger is seen |
| opt_disable | input | 1 | Suppress all triggering |
| opt_select | input | 1 | Forward only qualifying records |
| cross_in | input | 1 | Cross-trigger flag from the partner module |
| trig_clr | input | 1 | Clear both trigger flags |
| link_rst | input | 1 | Link reset, also clears both flags |
| out_valid | output | 1 | Output record present |
| out_hdr | output | PKTS*HDR_W | Forwarded headers |
| out_tag | output | 1 | Record is tagged as trigger data |
| trig_local | output | 1 | Latched local trigger, fed to the partner |
| trig_cross | output | 1 | Latched cross trigger |

## Verification
The assertions watch a set of cycle-to-cycle rules on every clock:
- the stickiness of both flags (R6, R7);
- that a rising local flag coincides with a tagged record;
- that disable or an unmet cross-trigger wait leaves the next record untagged (R8, R9);
- that select mode lets only tagged records out (R10).

Only the bench's scenarios can show that the ternary compare picks the right headers. These scenarios cover don't-care low bits, cared mismatches, exact type gating, unused terms, empty slots and hits in a non-zero slot (R2 to R5). They also confirm that the forwarded header is the one that went in.

// File: rtl/trig_sop_matcher.sv
module trig_sop_matcher #(
  parameter int NTERM  = 4,
  parameter int PKTS   = 4,
  parameter int HDR_W  = 32,
  parameter int TYPE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rec_valid,
  input  logic [PKTS*HDR_W-1:0]   rec_hdr,
  input  logic [PKTS*TYPE_W-1:0]  rec_ptype,
  input  logic [PKTS-1:0]         rec_pvld,
  input  logic [NTERM*TYPE_W-1:0] cfg_type,
  input  logic [NTERM*HDR_W-1:0]  cfg_val,
  input  logic [NTERM*HDR_W-1:0]  cfg_care,
  input  logic                    opt_wait_cross,
  input  logic                    opt_disable,
  input  logic                    opt_select,
  input  logic                    cross_in,
  input  logic                    trig_clr,
  input  logic                    link_rst,
  output logic                    out_valid,
  output logic [PKTS*HDR_W-1:0]   out_hdr,
  output logic                    out_tag,
  output logic                    trig_local,
  output logic                    trig_cross
);
  localparam int NPAIR = NTERM * PKTS;

  logic [NPAIR-1:0] pair_hit;
  logic             any_hit, armed, qual, flag_clr;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    for (genvar s = 0; s < PKTS; s++) begin : g_slot
      logic [TYPE_W-1:0] tcode;
      logic [HDR_W-1:0]  diff;
      assign tcode = cfg_type[t*TYPE_W +: TYPE_W];
      assign diff  = (rec_hdr[s*HDR_W +: HDR_W] ^ cfg_val[t*HDR_W +: HDR_W])
                     & cfg_care[t*HDR_W +: HDR_W];
      assign pair_hit[t*PKTS+s] = rec_pvld[s] && (tcode != '0)
                                  && (rec_ptype[s*TYPE_W +: TYPE_W] == tcode)
                                  && (diff == '0);
    end
  end

  assign any_hit  = |pair_hit;
  assign armed    = !opt_disable && (!opt_wait_cross || cross_in || trig_cross);
  assign qual     = rec_valid && any_hit && armed;
  assign flag_clr = trig_clr || link_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_tag    <= 1'b0;
      out_hdr    <= '0;
      trig_local <= 1'b0;
      trig_cross <= 1'b0;
    end else begin
      out_valid <= rec_valid && (!opt_select || qual);
      out_tag   <= qual;
      out_hdr   <= rec_hdr;
      if (flag_clr)      trig_local <= 1'b0;
      else if (qual)     trig_local <= 1'b1;
      if (flag_clr)      trig_cross <= 1'b0;
      else if (cross_in) trig_cross <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_sop_matcher_chk.sv
module trig_sop_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic opt_wait_cross,
  input logic opt_disable,
  input logic opt_select,
  input logic cross_in,
  input logic trig_clr,
  input logic link_rst,
  input logic out_valid,
  input logic out_tag,
  input logic trig_local,
  input logic trig_cross
);
  // R6
  local_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_local && !trig_clr && !link_rst) |=> trig_local);

  // R6
  local_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_clr || link_rst) |=> (!trig_local && !trig_cross));

  // R6
  local_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_local) |-> out_tag);

  // R7
  cross_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_in && !trig_clr && !link_rst) |=> trig_cross);

  // R7
  cross_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_cross && !trig_clr && !link_rst) |=> trig_cross);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wait_cross && !cross_in && !trig_cross) |=> !out_tag);

  // R9
  disabled_no_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_disable |=> (!out_tag && !$rose(trig_local)));

  // R10
  select_only_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opt_select |=> (!out_valid || out_tag));

  // R11
  tag_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_tag |-> out_valid);
endmodule

bind trig_sop_matcher trig_sop_matcher_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opt_wait_cross(opt_wait_cross),
  .opt_disable(opt_disable), .opt_select(opt_select), .cross_in(cross_in),
  .trig_clr(trig_clr), .link_rst(link_rst), .out_valid(out_valid),
  .out_tag(out_tag), .trig_local(trig_local), .trig_cross(trig_cross)
);

// File: tb/sim_trig_sop_matcher.sv
`timescale 1ns/1ps
module sim_trig_sop_matcher;
  localparam int NTERM = 4, PKTS = 4, HDR_W = 32, TYPE_W = 5;
  localparam int NVEC = 10;
  // {slot0 type, slot0 header, expected tag}
  localparam logic [37:0] VEC [NVEC] = '{
    {5'h01, 32'hFDFC0050, 1'b1},
    {5'h01, 32'hFDFC0053, 1'b1},
    {5'h01, 32'hFDFC0054, 1'b0},
    {5'h02, 32'h12345648, 1'b1},
    {5'h02, 32'h12345658, 1'b0},
    {5'h01, 32'h00000040, 1'b0},
    {5'h11, 32'h00000002, 1'b1},
    {5'h11, 32'h00000003, 1'b0},
    {5'h12, 32'hFDFC0050, 1'b0},
    {5'h00, 32'h00000000, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic rec_valid = 0;
  logic [PKTS*HDR_W-1:0] rec_hdr = '0;
  logic [PKTS*TYPE_W-1:0] rec_ptype = '0;
  logic [PKTS-1:0] rec_pvld = '0;
  logic [NTERM*TYPE_W-1:0] cfg_type = {5'h11, 5'h00, 5'h02, 5'h01};
  logic [NTERM*HDR_W-1:0] cfg_val  = {32'h0, 32'h0, 32'h00000040, 32'hFDFC0050};
  logic [NTERM*HDR_W-1:0] cfg_care = {32'h1, 32'h0, 32'h000000F0, 32'hFFFFFFFC};
  logic opt_wait_cross = 0, opt_disable = 0, opt_select = 0;
  logic cross_in = 0, trig_clr = 0, link_rst = 0;
  logic out_valid, out_tag, trig_local, trig_cross;
  logic [PKTS*HDR_W-1:0] out_hdr;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trig_sop_matcher #(.NTERM(NTERM), .PKTS(PKTS), .HDR_W(HDR_W), .TYPE_W(TYPE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_hdr(rec_hdr),
    .rec_ptype(rec_ptype), .rec_pvld(rec_pvld), .cfg_type(cfg_type),
    .cfg_val(cfg_val), .cfg_care(cfg_care), .opt_wait_cross(opt_wait_cross),
    .opt_disable(opt_disable), .opt_select(opt_select), .cross_in(cross_in),
    .trig_clr(trig_clr), .link_rst(link_rst), .out_valid(out_valid),
    .out_hdr(out_hdr), .out_tag(out_tag), .trig_local(trig_local),
    .trig_cross(trig_cross));

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [PKTS*TYPE_W-1:0] ty,
                      input logic [PKTS*HDR_W-1:0] hd, input logic [PKTS-1:0] pv,
                      input logic clr, input logic lrst, input logic xin);
    @(negedge clk);
    rec_valid = v; rec_ptype = ty; rec_hdr = hd; rec_pvld = pv;
    trig_clr = clr; link_rst = lrst; cross_in = xin;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic one(input logic [4:0] ty, input logic [31:0] hd);
    step(1'b1, {15'h0, ty}, {96'h0, hd}, 4'b0001, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 flags", {trig_local, trig_cross, out_tag}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R1 after release", {out_valid, out_tag, trig_local, trig_cross}, 0);

    // R2 R3 R4 R11: ternary compare table
    for (int i = 0; i < NVEC; i++) begin
      one(VEC[i][37:33], VEC[i][32:1]);
      check("R2 tag", out_tag, VEC[i][0]);
      check("R11 valid", out_valid, 1);
      check("R11 header", out_hdr, {96'h0, VEC[i][32:1]});
    end

    // R6: sticky local, clear by trig_clr
    check("R6 latched", trig_local, 1);
    idle(); idle();
    check("R6 held", trig_local, 1);
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
    check("R6 trig_clr", trig_local, 0);

    // R5: hit in slot 2, slot 1 empty
    step(1'b1, {5'h0, 5'h01, 5'h02, 5'h01}, {32'h0, 32'hFDFC0051, 32'h40, 32'h0},
         4'b0101, 1'b0, 1'b0, 1'b0);
    check("R5 slot2 hit", out_tag, 1);
    step(1'b1, {5'h0, 5'h0, 5'h02, 5'h01}, {32'h0, 32'h0, 32'h40, 32'h0},
         4'b0001, 1'b0, 1'b0, 1'b0);
    check("R5 empty slot ignored", out_tag, 0);
    check("R6 set by slot hit", trig_local, 1);
    step(1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b0);
    check("R6 link_rst", trig_local, 0);

    // R9: disable
    opt_disable = 1;
    one(5'h01, 32'hFDFC0050);
    check("R9 no tag", out_tag, 0);
    check("R9 no latch", trig_local, 0);
    check("R9 still forwarded", out_valid, 1);
    opt_disable = 0;

    // R8 R7: wait for cross trigger
    opt_wait_cross = 1;
    one(5'h01, 32'hFDFC0050);
    check("R8 held off", {out_tag, trig_local}, 0);
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b1);
    check("R7 cross set", trig_cross, 1);
    idle();
    check("R7 cross held", trig_cross, 1);
    one(5'h01, 32'hFDFC0050);
    check("R8 armed", {out_tag, trig_local}, 2'b11);
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, 1'b0);
    check("R7 cleared", {trig_cross, trig_local}, 0);
    opt_wait_cross = 0;

    // R10: select
    opt_select = 1;
    one(5'h01, 32'hFDFC0054);
    check("R10 dropped", out_valid, 0);
    one(5'h02, 32'h00000047);
    check("R10 kept", {out_valid, out_tag}, 2'b11);
    check("R10 header", out_hdr, {96'h0, 32'h00000047});
    opt_select = 0;
    idle();
    check("R11 idle no output", out_valid, 0);

    finished = 1;
    summary();
  end
endmodule